// File: doc/BRIEF.md
# SDRAM Bank Command State Tracker

This block sits beside the command stream of a multi-bank synchronous DRAM. It keeps a state machine for every bank and checks each command against the bank state. It also checks the minimum spacing rules, all counted in clock cycles: row-to-column delay, activate-to-activate delay, activate-to-precharge time and precharge recovery.

Each accepted command moves the addressed bank, or every bank for the device-wide commands, to its next state. When a command is illegal for the present state, or arrives before its spacing window has closed, a registered flag is raised one cycle later and no bank state changes. The block also models read and write burst windows and how other commands cut them short. A further output shows whether any bank is inside a read burst. Burst length, CAS latency and every timing limit are parameters.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every bank reports idle and both flags are low. State codes per bank are idle 0, row active 1, read 2, write 3, precharge 4, refresh 5, mode-set 6. Bank n occupies bank_state bits [3n+2:3n].
- R2: An activate (code 3) to an idle bank, with the activate spacing met, puts that bank in row active on the next cycle.
- R3: A read (4), read with auto-precharge (5), write (6) or write with auto-precharge (7) issued fewer than T_RCD cycles after that bank's activate raises the timing flag and leaves the bank state unchanged.
- R4: An activate issued fewer than T_RRD cycles after the previous accepted activate raises the timing flag. An activate to a bank that is already open raises the illegal flag. In both cases the bank state is unchanged.
- R5: A precharge (8) or precharge-all (9) reaching an open bank fewer than T_RAS cycles after its activate raises the timing flag. Otherwise the bank(s) enter precharge and return to idle T_RP cycles after the command. An activate during that window raises the timing flag.
- R6: A read keeps the bank in the read state for CAS_LAT+BURST_LEN-1 cycles after the command. The bank then returns to row active, or to precharge for a read with auto-precharge. read_burst_active is high exactly while some bank is in the read state.
- R7: Burst stop (2) returns every bank in read or write to row active. A new read during a read burst restarts the burst window from the new command.
- R8: A write during a read moves the bank to write, which lasts BURST_LEN-1 cycles before row active. A precharge during a read ends the burst and enters precharge.
- R9: In idle, deselect (0), no-op (1), burst stop, precharge and precharge-all change nothing and raise no flag.
- R10: With all banks idle, auto-refresh (10) puts all banks in refresh for T_RFC-1 cycles and mode-register-set (13) puts all banks in mode-set for T_MRD-1 cycles; both then return to idle. Self-refresh entry (11) holds refresh until self-refresh exit (12), after which refresh lasts T_RFC-1 more cycles. Commands other than deselect, no-op and burst stop during refresh or mode-set, refresh with an open bank, and exit with self-refresh inactive raise the illegal flag.
- R11: Both flags are registered and appear on the cycle after the offending command. The two flags are never high together. Undefined codes (14, 15) raise the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 4 | Decoded command code (see R2 to R11) |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank address of the command |
| bank_state | output | 3*NUM_BANKS | Per-bank state codes, bank 0 in the low bits |
| cmd_illegal | output | 1 | Previous command was illegal for the bank state |
| cmd_timing_err | output | 1 | Previous command broke a spacing limit |
| read_burst_active | output | 1 | Some bank is inside a read burst |

## Verification
The assertions assume that cmd_code and cmd_bank carry known values whenever cmd_valid is high. They also assume that every timing parameter is at least 2, so that each counted window has at least one cycle. The stimulus drives every input on the falling clock edge from a single driver task, with cmd_valid low outside commands. Illegal and early commands are issued on purpose, but the bank address always names an existing bank, and the parameters stay at their defaults.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [3:0] {
    C_DESL = 4'd0,  C_NOP  = 4'd1,  C_BST  = 4'd2,  C_ACT  = 4'd3,
    C_RD   = 4'd4,  C_RDA  = 4'd5,  C_WR   = 4'd6,  C_WRA  = 4'd7,
    C_PRE  = 4'd8,  C_PALL = 4'd9,  C_REF  = 4'd10, C_SELF = 4'd11,
    C_SELX = 4'd12, C_MRS  = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_ACT = 3'd1, ST_RD  = 3'd2, ST_WR = 3'd3,
    ST_PRE  = 3'd4, ST_REF = 3'd5, ST_MRS = 3'd6
  } bank_st_e;

  typedef enum logic [3:0] {
    A_NONE, A_ACT, A_RD, A_RDA, A_WR, A_WRA, A_PRE, A_BST,
    A_REF, A_SELF, A_SELX, A_MRS
  } bank_act_e;

endpackage

// File: rtl/sdt_gap_timer.sv
module sdt_gap_timer #(
  parameter int GAP = 2,
  parameter int CW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic ok_o
);
  localparam logic [CW-1:0] LOAD = CW'(GAP - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire_i)           cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok_o = (cnt_q == '0);

  p_act_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> ok_o);

endmodule

// File: rtl/sdt_bank.sv
module sdt_bank
  import sdt_pkg::*;
#(
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RFC     = 5,
  parameter int T_MRD     = 2,
  parameter int CW        = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bank_act_e act_i,
  output bank_st_e  st_o,
  output logic      rcd_ok_o,
  output logic      ras_ok_o,
  output logic      self_o
);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] LD_RD  = CW'(CAS_LAT + BURST_LEN - 1);
  localparam logic [CW-1:0] LD_WR  = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RFC = CW'(T_RFC - 1);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 1);

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, rcd_q, rcd_d, ras_q, ras_d;
  logic          autop_q, autop_d, self_q, self_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    autop_d = autop_q;
    self_d  = self_q;
    rcd_d   = (rcd_q != '0) ? rcd_q - 1'b1 : rcd_q;
    ras_d   = (ras_q != '0) ? ras_q - 1'b1 : ras_q;

    // window timers
    unique case (st_q)
      ST_PRE, ST_MRS: begin
        if (cnt_q <= ONE) st_d = ST_IDLE;
        else              cnt_d = cnt_q - 1'b1;
      end
      ST_RD, ST_WR: begin
        if (cnt_q <= ONE) begin
          st_d    = autop_q ? ST_PRE : ST_ACT;
          cnt_d   = autop_q ? LD_RP : '0;
          autop_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_REF: begin
        if (!self_q) begin
          if (cnt_q <= ONE) st_d = ST_IDLE;
          else              cnt_d = cnt_q - 1'b1;
        end
      end
      default: ;
    endcase

    // accepted commands override the timers
    unique case (act_i)
      A_ACT:  begin st_d = ST_ACT; rcd_d = LD_RCD; ras_d = LD_RAS; end
      A_RD:   begin st_d = ST_RD;  cnt_d = LD_RD;  autop_d = 1'b0; end
      A_RDA:  begin st_d = ST_RD;  cnt_d = LD_RD;  autop_d = 1'b1; end
      A_WR:   begin st_d = ST_WR;  cnt_d = LD_WR;  autop_d = 1'b0; end
      A_WRA:  begin st_d = ST_WR;  cnt_d = LD_WR;  autop_d = 1'b1; end
      A_PRE:  begin st_d = ST_PRE; cnt_d = LD_RP;  autop_d = 1'b0; end
      A_BST:  begin st_d = ST_ACT; autop_d = 1'b0; end
      A_REF:  begin st_d = ST_REF; cnt_d = LD_RFC; end
      A_SELF: begin st_d = ST_REF; self_d = 1'b1; end
      A_SELX: begin st_d = ST_REF; self_d = 1'b0; cnt_d = LD_RFC; end
      A_MRS:  begin st_d = ST_MRS; cnt_d = LD_MRD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rcd_q   <= '0;
      ras_q   <= '0;
      autop_q <= 1'b0;
      self_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rcd_q   <= rcd_d;
      ras_q   <= ras_d;
      autop_q <= autop_d;
      self_q  <= self_d;
    end
  end

  assign st_o     = st_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign ras_ok_o = (ras_q == '0);
  assign self_o   = self_q;

  p_act_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == A_ACT) |-> (st_q == ST_IDLE));
  p_col_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i inside {A_RD, A_RDA, A_WR, A_WRA}) |-> rcd_ok_o);
  p_pre_after_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == A_PRE) |-> ras_ok_o);
  p_read_not_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD) |=> (st_q != ST_IDLE));

endmodule

// File: rtl/sdt_cmd_check.sv
module sdt_cmd_check
  import sdt_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic            valid_i,
  input  logic [3:0]      code_i,
  input  logic [BW-1:0]   bank_i,
  input  bank_st_e        st_i     [NB],
  input  logic [NB-1:0]   rcd_ok_i,
  input  logic [NB-1:0]   ras_ok_i,
  input  logic            rrd_ok_i,
  input  logic            self_i,
  output logic            illegal_o,
  output logic            timing_o,
  output bank_act_e       act_o    [NB]
);
  cmd_e     code;
  bank_st_e cur;
  logic     cur_open, busy, any_open, any_pre, ras_bad;

  assign code     = cmd_e'(code_i);
  assign cur      = st_i[bank_i];
  assign cur_open = (cur == ST_ACT) || (cur == ST_RD) || (cur == ST_WR);

  always_comb begin
    busy = 1'b0; any_open = 1'b0; any_pre = 1'b0; ras_bad = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (st_i[b] == ST_REF || st_i[b] == ST_MRS) busy = 1'b1;
      if (st_i[b] == ST_PRE) any_pre = 1'b1;
      if (st_i[b] == ST_ACT || st_i[b] == ST_RD || st_i[b] == ST_WR) begin
        any_open = 1'b1;
        if (!ras_ok_i[b]) ras_bad = 1'b1;
      end
    end
  end

  always_comb begin
    illegal_o = 1'b0;
    timing_o  = 1'b0;
    for (int b = 0; b < NB; b++) act_o[b] = A_NONE;
    if (valid_i) begin
      if (code == C_SELX) begin
        if (self_i) for (int b = 0; b < NB; b++) act_o[b] = A_SELX;
        else        illegal_o = 1'b1;
      end else if (code == C_DESL || code == C_NOP) begin
        illegal_o = 1'b0;
      end else if (busy) begin
        illegal_o = (code != C_BST);
      end else begin
        case (code)
          C_BST:
            for (int b = 0; b < NB; b++)
              if (st_i[b] == ST_RD || st_i[b] == ST_WR) act_o[b] = A_BST;
          C_ACT: begin
            if (cur == ST_PRE)       timing_o  = 1'b1;
            else if (cur != ST_IDLE) illegal_o = 1'b1;
            else if (!rrd_ok_i)      timing_o  = 1'b1;
            else                     act_o[bank_i] = A_ACT;
          end
          C_RD, C_RDA, C_WR, C_WRA: begin
            if (!cur_open)              illegal_o = 1'b1;
            else if (!rcd_ok_i[bank_i]) timing_o  = 1'b1;
            else case (code)
              C_RD:    act_o[bank_i] = A_RD;
              C_RDA:   act_o[bank_i] = A_RDA;
              C_WR:    act_o[bank_i] = A_WR;
              default: act_o[bank_i] = A_WRA;
            endcase
          end
          C_PRE: begin
            if (cur_open) begin
              if (!ras_ok_i[bank_i]) timing_o = 1'b1;
              else                   act_o[bank_i] = A_PRE;
            end
          end
          C_PALL: begin
            if (ras_bad) timing_o = 1'b1;
            else
              for (int b = 0; b < NB; b++)
                if (st_i[b] == ST_ACT || st_i[b] == ST_RD || st_i[b] == ST_WR)
                  act_o[b] = A_PRE;
          end
          C_REF, C_SELF, C_MRS: begin
            if (any_open)     illegal_o = 1'b1;
            else if (any_pre) timing_o  = 1'b1;
            else
              for (int b = 0; b < NB; b++)
                act_o[b] = (code == C_REF)  ? A_REF :
                           (code == C_SELF) ? A_SELF : A_MRS;
          end
          default: illegal_o = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RFC     = 5,
  parameter int T_MRD     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [3:0]                   cmd_code,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic [3*NUM_BANKS-1:0]       bank_state,
  output logic                         cmd_illegal,
  output logic                         cmd_timing_err,
  output logic                         read_burst_active
);
  localparam int BW = $clog2(NUM_BANKS);
  localparam int CW = $clog2(CAS_LAT + BURST_LEN + T_RP + T_RCD + T_RRD +
                             T_RAS + T_RFC + T_MRD + 1);

  logic [1:0]           rs_q;
  logic                 rst_int;
  bank_st_e             st_v   [NUM_BANKS];
  bank_act_e            act_v  [NUM_BANKS];
  logic [NUM_BANKS-1:0] rcd_ok, ras_ok, self_v;
  logic                 rrd_ok, act_fire, ill_d, te_d, ill_q, te_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  sdt_cmd_check #(.NB(NUM_BANKS), .BW(BW)) u_check (
    .valid_i (cmd_valid), .code_i (cmd_code), .bank_i (cmd_bank),
    .st_i    (st_v),      .rcd_ok_i (rcd_ok), .ras_ok_i (ras_ok),
    .rrd_ok_i (rrd_ok),   .self_i (|self_v),
    .illegal_o (ill_d),   .timing_o (te_d),   .act_o (act_v)
  );

  always_comb begin
    act_fire = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (act_v[b] == A_ACT) act_fire = 1'b1;
  end

  sdt_gap_timer #(.GAP(T_RRD), .CW(CW)) u_rrd (
    .clk (clk), .rst_n (rst_int), .fire_i (act_fire), .ok_o (rrd_ok)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdt_bank #(
      .CAS_LAT (CAS_LAT), .BURST_LEN (BURST_LEN), .T_RP (T_RP),
      .T_RCD (T_RCD), .T_RAS (T_RAS), .T_RFC (T_RFC), .T_MRD (T_MRD),
      .CW (CW)
    ) u_bank (
      .clk (clk), .rst_n (rst_int), .act_i (act_v[g]), .st_o (st_v[g]),
      .rcd_ok_o (rcd_ok[g]), .ras_ok_o (ras_ok[g]), .self_o (self_v[g])
    );
    assign bank_state[3*g +: 3] = st_v[g];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ill_q <= 1'b0;
      te_q  <= 1'b0;
    end else begin
      ill_q <= ill_d;
      te_q  <= te_d;
    end
  end

  assign cmd_illegal    = ill_q;
  assign cmd_timing_err = te_q;

  always_comb begin
    read_burst_active = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (st_v[b] == ST_RD) read_burst_active = 1'b1;
  end

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_int)
    !(cmd_illegal && cmd_timing_err));
  p_flag_after_cmd_r11: assert property (@(posedge clk) disable iff (!rst_int)
    (cmd_illegal || cmd_timing_err) |-> $past(cmd_valid));

endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] bank_state;
  logic        cmd_illegal, cmd_timing_err, read_burst_active;

  always #4 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
    .cmd_bank (cmd_bank), .bank_state (bank_state), .cmd_illegal (cmd_illegal),
    .cmd_timing_err (cmd_timing_err), .read_burst_active (read_burst_active)
  );

  localparam logic [3:0] DESL = 0, NOP = 1, BST = 2, ACT = 3, RD = 4, RDA = 5,
    WR = 6, PRE = 8, PALL = 9, REF = 10, SELF = 11, SELX = 12, MRS = 13;
  localparam logic [2:0] I = 0, A = 1, R = 2, W = 3, P = 4, F = 5, M = 6;

  typedef struct {
    int          due;
    logic [11:0] st;
    logic        ill, te, rb;
    string       tag;
  } exp_t;

  exp_t       sbq[$];
  logic [2:0] es [NB];
  int         cyc = 0, n_chk = 0, n_err = 0;
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] pack_es();
    logic [11:0] v;
    for (int b = 0; b < NB; b++) v[3*b +: 3] = es[b];
    return v;
  endfunction

  function automatic void set_all(logic [2:0] s);
    for (int b = 0; b < NB; b++) es[b] = s;
  endfunction

  // driver: one command per cycle, expectation pushed to the scoreboard
  task automatic go(input logic [3:0] c, input int b, input logic ill,
                    input logic te, input string tag);
    exp_t e;
    logic rb;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_bank = 2'(b);
    rb = 1'b0;
    for (int k = 0; k < NB; k++) if (es[k] == R) rb = 1'b1;
    e.due = cyc + 1; e.st = pack_es(); e.ill = ill; e.te = te; e.rb = rb;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic nop(input string tag);
    go(NOP, 0, 1'b0, 1'b0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_chk++;
      if (bank_state !== e.st || cmd_illegal !== e.ill ||
          cmd_timing_err !== e.te || read_burst_active !== e.rb) begin
        n_err++;
        $display("FAIL %s: actual st=%h ill=%b te=%b rb=%b expected st=%h ill=%b te=%b rb=%b",
                 e.tag, bank_state, cmd_illegal, cmd_timing_err, read_burst_active,
                 e.st, e.ill, e.te, e.rb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 4'd0; cmd_bank = 2'd0;
    set_all(I);
    repeat (3) @(negedge clk);
    n_chk++;
    if (bank_state !== 12'h000 || cmd_illegal !== 1'b0 || cmd_timing_err !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset: actual st=%h ill=%b te=%b expected st=000 ill=0 te=0",
               bank_state, cmd_illegal, cmd_timing_err);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nop("R1 after release");

    // R2 / R3 / R4 / R5 activate and spacing
    es[0] = A; go(ACT, 0, 0, 0, "R2 act bank0");
    go(RD, 0, 0, 1, "R3 read before tRCD");
    es[1] = A; go(ACT, 1, 0, 0, "R2 act bank1");
    go(ACT, 2, 0, 1, "R4 act before tRRD");
    go(ACT, 1, 1, 0, "R4 act open bank");
    go(PRE, 0, 0, 1, "R5 pre before tRAS");

    // R6 plain read burst
    es[0] = R; go(RD, 0, 0, 0, "R6 read start");
    for (int k = 0; k < 4; k++) nop("R6 burst");
    es[0] = A; nop("R6 burst end");

    // R7 read restarts, burst stop
    es[0] = R; go(RD, 0, 0, 0, "R7 read");
    nop("R7 burst");
    go(RD, 0, 0, 0, "R7 second read");
    for (int k = 0; k < 4; k++) nop("R7 restarted burst");
    es[0] = A; nop("R7 restarted end");
    es[0] = R; go(RD, 0, 0, 0, "R7 read");
    es[0] = A; go(BST, 0, 0, 0, "R7 burst stop");

    // R8 write and precharge cut a read
    es[0] = R; go(RD, 0, 0, 0, "R8 read");
    es[0] = W; go(WR, 0, 0, 0, "R8 write in read");
    nop("R8 write burst"); nop("R8 write burst");
    es[0] = A; nop("R8 write end");
    es[1] = R; go(RD, 1, 0, 0, "R8 read bank1");
    es[1] = P; go(PRE, 1, 0, 0, "R8 pre in read");
    go(ACT, 1, 0, 1, "R5 act during precharge");
    es[1] = I; nop("R5 precharge done");

    // R6 read with auto-precharge
    es[0] = R; go(RDA, 0, 0, 0, "R6 read autopre");
    for (int k = 0; k < 4; k++) nop("R6 autopre burst");
    es[0] = P; nop("R6 autopre precharge");
    nop("R6 autopre precharge");
    es[0] = I; nop("R6 autopre idle");

    // R9 idle no-ops
    go(PRE, 0, 0, 0, "R9 pre idle");
    go(PALL, 0, 0, 0, "R9 pall idle");
    go(BST, 0, 0, 0, "R9 bst idle");
    go(DESL, 0, 0, 0, "R9 desl idle");

    // R10 refresh, mode set, self refresh
    set_all(F); go(REF, 0, 0, 0, "R10 refresh");
    go(ACT, 0, 1, 0, "R10 act during refresh");
    nop("R10 refresh"); nop("R10 refresh");
    set_all(I); nop("R10 refresh done");
    set_all(M); go(MRS, 0, 0, 0, "R10 mode set");
    set_all(I); nop("R10 mode set done");
    set_all(F); go(SELF, 0, 0, 0, "R10 self entry");
    nop("R10 self hold"); nop("R10 self hold");
    go(SELX, 0, 0, 0, "R10 self exit");
    for (int k = 0; k < 3; k++) nop("R10 exit window");
    set_all(I); nop("R10 exit done");
    go(SELX, 0, 1, 0, "R10 exit without self");

    // R5 / R10 precharge-all spacing and refresh with open bank
    es[3] = A; go(ACT, 3, 0, 0, "R2 act bank3");
    go(REF, 0, 1, 0, "R10 refresh with open bank");
    go(PALL, 0, 0, 1, "R5 pall before tRAS");
    for (int k = 0; k < 3; k++) nop("R5 wait tRAS");
    es[3] = P; go(PALL, 0, 0, 0, "R5 pall");
    nop("R5 pall precharge");
    es[3] = I; nop("R5 pall idle");

    // R11 undefined code
    go(4'hF, 0, 1, 0, "R11 undefined code");
    nop("R11 flag clears");

    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule